// File: doc/BRIEF.md
# Microprogram Sequencer with Field Decode

This block is the control unit of a small microcoded machine. A 5-bit microaddress register selects one 30-bit word from a 32-entry control store. The control store's contents are set through a parameter. The selected word is decoded in the same cycle into the strobes and codes that steer the datapath: register read and write enables, a memory operation code and an ALU function code. Two status lines are also decoded from it.

The low thirteen bits of each word choose the following microaddress. A 3-bit test selector picks one of five rules:
- branch on the button;
- branch on the accumulator-zero flag;
- dispatch on the mode knob;
- dispatch on the instruction opcode;
- an unconditional jump to the base address.

The register loads the chosen address on every clock edge. There is no incrementing counter, so every word names its own successor explicitly. The block has no streaming data interface; all of its pins are plain control and status levels.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads microaddress 0, visible on `upc` after that edge.
- R2: When word bits [2:0] equal 1, the next microaddress is bits [7:3] if `button` is high and bits [12:8] otherwise.
- R3: When word bits [2:0] equal 2, the next microaddress is bits [7:3] if `acc_zero` is high and bits [12:8] otherwise.
- R4: When word bits [2:0] equal 3, the next microaddress is bits [12:8] plus `knob`, modulo 32, with no extra increment.
- R5: When word bits [2:0] equal 4, the next microaddress is bits [12:8] plus `opcode`, modulo 32.
- R6: For selector values 0, 5, 6 and 7, the next microaddress is bits [12:8] regardless of `button`, `acc_zero`, `knob` and `opcode`.
- R7: Single-bit outputs equal word bits of the current microaddress in the same cycle: `sw_rd`=28, `mar_wr`=27, `pc_wr`=24, `pc_rd`=23, `acc_wr`=22, `acc_rd`=21, `ir_wr`=20, `ir_rd`=19, `arg_wr`=18, `buf_rd`=15, `ready`=14, `idle`=13.
- R8: `mem_code` equals word bits [26:25] and `alu_code` equals word bits [17:16] of the current word.
- R9: Word bit 29 affects no output; outputs for a word with bit 29 set match those predicted from bits [28:0] alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| knob | input | 2 | Mode selector used by dispatch rule 3 |
| button | input | 1 | Operator button used by branch rule 1 |
| acc_zero | input | 1 | High when the accumulator is zero |
| opcode | input | 3 | Instruction opcode used by dispatch rule 4 |
| upc | output | 5 | Current microaddress |
| sw_rd | output | 1 | Drive switches onto bus |
| mar_wr | output | 1 | Load memory address register |
| pc_wr | output | 1 | Load program counter |
| pc_rd | output | 1 | Drive program counter onto bus |
| acc_wr | output | 1 | Load accumulator |
| acc_rd | output | 1 | Drive accumulator onto bus |
| ir_wr | output | 1 | Load instruction register |
| ir_rd | output | 1 | Drive instruction register onto bus |
| arg_wr | output | 1 | Load ALU argument register |
| buf_rd | output | 1 | Drive ALU result buffer onto bus |
| ready | output | 1 | Machine ready status |
| idle | output | 1 | Machine idle status |
| mem_code | output | 2 | Memory operation code |
| alu_code | output | 2 | ALU function code |

## Verification
On every cycle, the bound checker checks each sequencing rule. After a word with a given selector, the checker compares `upc` against the branch or dispatch target formed from the previous word and the previous inputs. It also checks the return to address 0 after reset.

The exact strobe and code positions are shown only by the bench scenarios, which run a scoreboarded walk through a bench-built program. The same applies to the modulo-32 wrap of the dispatch sums and to the irrelevance of bit 29. The bench predicts every output from its own copy of the program and its own model of the rules.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W  = 5;
  localparam int WORD_W  = 30;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int TEST_W  = 3;

  // next-address fields
  localparam int B_LSB   = 3;
  localparam int A_LSB   = B_LSB + ADDR_W;
  localparam int CTL_LSB = A_LSB + ADDR_W;

  // control bit positions
  localparam int P_IDLE  = 13;
  localparam int P_READY = 14;
  localparam int P_BUFRD = 15;
  localparam int P_ALU   = 16;
  localparam int P_ARGWR = 18;
  localparam int P_IRRD  = 19;
  localparam int P_IRWR  = 20;
  localparam int P_ACCRD = 21;
  localparam int P_ACCWR = 22;
  localparam int P_PCRD  = 23;
  localparam int P_PCWR  = 24;
  localparam int P_MEM   = 25;
  localparam int P_MARWR = 27;
  localparam int P_SWRD  = 28;

  typedef enum logic [TEST_W-1:0] {
    SEL_JUMP   = 3'd0,
    SEL_BUTTON = 3'd1,
    SEL_ZERO   = 3'd2,
    SEL_KNOB   = 3'd3,
    SEL_OPCODE = 3'd4
  } sel_e;

  typedef struct packed {
    logic       sw_rd;
    logic       mar_wr;
    logic       pc_wr;
    logic       pc_rd;
    logic       acc_wr;
    logic       acc_rd;
    logic       ir_wr;
    logic       ir_rd;
    logic       arg_wr;
    logic       buf_rd;
    logic       ready;
    logic       idle;
    logic [1:0] mem_code;
    logic [1:0] alu_code;
  } strobe_t;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = useq_pkg::ADDR_W,
  parameter int WORD_W = useq_pkg::WORD_W,
  parameter logic [(1<<ADDR_W)*WORD_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign rows[g] = IMAGE[g*WORD_W +: WORD_W];
  end

  assign word = rows[addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [A_LSB+ADDR_W-1:0] low,
  input  logic [1:0]              knob,
  input  logic                    button,
  input  logic                    acc_zero,
  input  logic [2:0]              opcode,
  output logic [ADDR_W-1:0]       nxt
);
  logic [ADDR_W-1:0] base, alt;
  sel_e              sel;

  assign sel  = sel_e'(low[TEST_W-1:0]);
  assign alt  = low[B_LSB +: ADDR_W];
  assign base = low[A_LSB +: ADDR_W];

  always_comb begin
    case (sel)
      SEL_BUTTON: nxt = button   ? alt : base;
      SEL_ZERO:   nxt = acc_zero ? alt : base;
      SEL_KNOB:   nxt = base + ADDR_W'(knob);
      SEL_OPCODE: nxt = base + ADDR_W'(opcode);
      default:    nxt = base;
    endcase
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [WORD_W-1:CTL_LSB] hi,
  output strobe_t                 st
);
  logic unused_spare;
  assign unused_spare = hi[WORD_W-1];

  always_comb begin
    st.sw_rd    = hi[P_SWRD];
    st.mar_wr   = hi[P_MARWR];
    st.pc_wr    = hi[P_PCWR];
    st.pc_rd    = hi[P_PCRD];
    st.acc_wr   = hi[P_ACCWR];
    st.acc_rd   = hi[P_ACCRD];
    st.ir_wr    = hi[P_IRWR];
    st.ir_rd    = hi[P_IRRD];
    st.arg_wr   = hi[P_ARGWR];
    st.buf_rd   = hi[P_BUFRD];
    st.ready    = hi[P_READY];
    st.idle     = hi[P_IDLE];
    st.mem_code = hi[P_MEM +: 2];
    st.alu_code = hi[P_ALU +: 2];
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  knob,
  input  logic        button,
  input  logic        acc_zero,
  input  logic [2:0]  opcode,
  output logic [4:0]  upc,
  output logic        sw_rd,
  output logic        mar_wr,
  output logic        pc_wr,
  output logic        pc_rd,
  output logic        acc_wr,
  output logic        acc_rd,
  output logic        ir_wr,
  output logic        ir_rd,
  output logic        arg_wr,
  output logic        buf_rd,
  output logic        ready,
  output logic        idle,
  output logic [1:0]  mem_code,
  output logic [1:0]  alu_code
);
  logic [WORD_W-1:0] uword;
  logic [ADDR_W-1:0] nxt;
  strobe_t           st;

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IMAGE(IMAGE)) i_store (
    .addr(upc), .word(uword)
  );

  useq_next i_next (
    .low(uword[A_LSB+ADDR_W-1:0]), .knob(knob), .button(button),
    .acc_zero(acc_zero), .opcode(opcode), .nxt(nxt)
  );

  useq_decode i_decode (.hi(uword[WORD_W-1:CTL_LSB]), .st(st));

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end

  assign sw_rd    = st.sw_rd;
  assign mar_wr   = st.mar_wr;
  assign pc_wr    = st.pc_wr;
  assign pc_rd    = st.pc_rd;
  assign acc_wr   = st.acc_wr;
  assign acc_rd   = st.acc_rd;
  assign ir_wr    = st.ir_wr;
  assign ir_rd    = st.ir_rd;
  assign arg_wr   = st.arg_wr;
  assign buf_rd   = st.buf_rd;
  assign ready    = st.ready;
  assign idle     = st.idle;
  assign mem_code = st.mem_code;
  assign alu_code = st.alu_code;
endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  upc,
  input logic [29:0] uword,
  input logic [1:0]  knob,
  input logic        button,
  input logic        acc_zero,
  input logic [2:0]  opcode
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> upc == 5'd0);

  assert_button_R2: assert property (@(posedge clk) disable iff (rst)
    uword[2:0] == 3'd1 |=>
      upc == ($past(button) ? $past(uword[7:3]) : $past(uword[12:8])));

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    uword[2:0] == 3'd2 |=>
      upc == ($past(acc_zero) ? $past(uword[7:3]) : $past(uword[12:8])));

  assert_knob_R4: assert property (@(posedge clk) disable iff (rst)
    uword[2:0] == 3'd3 |=>
      upc == 5'($past(uword[12:8]) + 5'($past(knob))));

  assert_opcode_R5: assert property (@(posedge clk) disable iff (rst)
    uword[2:0] == 3'd4 |=>
      upc == 5'($past(uword[12:8]) + 5'($past(opcode))));

  assert_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (uword[2:0] == 3'd0 || uword[2:0] > 3'd4) |=> upc == $past(uword[12:8]));
endmodule

bind useq_top useq_checker i_chk (
  .clk(clk), .rst(rst), .upc(upc), .uword(uword), .knob(knob),
  .button(button), .acc_zero(acc_zero), .opcode(opcode)
);

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;
  localparam int W = 30;
  localparam int N = 32;

  function automatic logic [N*W-1:0] build_prog();
    logic [N*W-1:0] img;
    img = '0;
    for (int i = 0; i < N; i++) begin
      logic [2:0]  t;
      logic [4:0]  a, b;
      logic [16:0] h;
      t = 3'(i % 8);
      b = 5'((i * 7 + 3) % 32);
      if (t == 3'd3 || t == 3'd4) a = 5'(31 - i / 8);
      else                        a = 5'((i * 11 + 5) % 32);
      h = 17'((i * 40503) ^ (i << 9) ^ 17'h0B3C5);
      img[i*W +: W] = {h, a, b, t};
    end
    return img;
  endfunction

  localparam logic [N*W-1:0] PROG = build_prog();

  logic clk = 1'b0, rst = 1'b1, button = 1'b0, acc_zero = 1'b0;
  logic [1:0] knob = '0;
  logic [2:0] opcode = '0;
  logic [4:0] upc;
  logic sw_rd, mar_wr, pc_wr, pc_rd, acc_wr, acc_rd, ir_wr, ir_rd;
  logic arg_wr, buf_rd, ready, idle;
  logic [1:0] mem_code, alu_code;

  always #4 clk = ~clk;

  useq_top #(.IMAGE(PROG)) i_useq_top (
    .clk(clk), .rst(rst), .knob(knob), .button(button), .acc_zero(acc_zero),
    .opcode(opcode), .upc(upc), .sw_rd(sw_rd), .mar_wr(mar_wr), .pc_wr(pc_wr),
    .pc_rd(pc_rd), .acc_wr(acc_wr), .acc_rd(acc_rd), .ir_wr(ir_wr),
    .ir_rd(ir_rd), .arg_wr(arg_wr), .buf_rd(buf_rd), .ready(ready),
    .idle(idle), .mem_code(mem_code), .alu_code(alu_code)
  );

  typedef struct {
    logic [4:0]  pc;
    logic [11:0] bits;
    logic [3:0]  codes;
    string       tag;
    logic        spare;
  } item_t;

  item_t q[$];
  int vectors = 0, miscompares = 0;
  logic [4:0] model_pc = '0;
  string      model_tag = "R1";
  bit         started = 0;

  function automatic logic [29:0] word_at(logic [4:0] a);
    return PROG[int'(a)*W +: W];
  endfunction

  // R7 positions, R8 fields
  function automatic logic [11:0] exp_bits(logic [29:0] w);
    return {w[28], w[27], w[24], w[23], w[22], w[21], w[20], w[19], w[18],
            w[15], w[14], w[13]};
  endfunction

  function automatic logic [4:0] model_next(logic [29:0] w, logic [1:0] k,
                                            logic bt, logic z, logic [2:0] op);
    case (w[2:0])
      3'd1:    return bt ? w[7:3] : w[12:8];
      3'd2:    return z  ? w[7:3] : w[12:8];
      3'd3:    return 5'(w[12:8] + 5'(k));
      3'd4:    return 5'(w[12:8] + 5'(op));
      default: return w[12:8];
    endcase
  endfunction

  function automatic string sel_tag(logic [2:0] t);
    case (t)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic r, input logic [1:0] k, input logic bt,
                      input logic z, input logic [2:0] op);
    item_t it;
    logic [29:0] w;
    @(negedge clk);
    rst = r; knob = k; button = bt; acc_zero = z; opcode = op;
    w = word_at(model_pc);
    if (started) begin
      it.pc = model_pc; it.bits = exp_bits(w); it.codes = {w[26:25], w[17:16]};
      it.tag = model_tag; it.spare = w[29];
      q.push_back(it);
    end
    if (r) begin model_pc = '0; model_tag = "R1"; end
    else begin
      model_pc = model_next(w, k, bt, z, op);
      model_tag = sel_tag(w[2:0]);
    end
  endtask

  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [11:0] got_bits;
      logic [3:0]  got_codes;
      bit bad;
      it = q.pop_front();
      got_bits  = {sw_rd, mar_wr, pc_wr, pc_rd, acc_wr, acc_rd, ir_wr, ir_rd,
                   arg_wr, buf_rd, ready, idle};
      got_codes = {mem_code, alu_code};
      bad = 0;
      vectors++;
      if (upc !== it.pc) begin
        $display("FAIL %s upc got %0d expected %0d", it.tag, upc, it.pc);
        bad = 1;
      end
      if (got_bits !== it.bits) begin
        $display("FAIL %s strobes got %b expected %b",
                 it.spare ? "R9" : "R7", got_bits, it.bits);
        bad = 1;
      end
      if (got_codes !== it.codes) begin
        $display("FAIL %s mem/alu codes got %b expected %b",
                 it.spare ? "R9" : "R8", got_codes, it.codes);
        bad = 1;
      end
      if (bad) miscompares++;
    end
  end

  initial begin
    #1600000;
    $display("FAIL watchdog expired");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 2'($urandom), 1'($urandom), ($urandom % 3) == 0, 3'($urandom));
  endtask

  initial begin
    step(1'b1, 2'd0, 1'b0, 1'b0, 3'd0);
    step(1'b1, 2'd0, 1'b0, 1'b0, 3'd0);
    model_pc = '0; model_tag = "R1"; started = 1;
    // R1 reset state, then R2..R9 over a random walk of the program
    run_random(1200);
    // saturated inputs to push dispatch sums past 31 (R4, R5)
    for (int i = 0; i < 200; i++) step(1'b0, 2'd3, 1'b1, 1'b1, 3'd7);
    // R6 selectors ignore inputs: all-low inputs
    for (int i = 0; i < 100; i++) step(1'b0, 2'd0, 1'b0, 1'b0, 3'd0);
    // mid-run reset (R1)
    step(1'b1, 2'd2, 1'b1, 1'b0, 3'd5);
    run_random(400);
    step(1'b0, 2'd0, 1'b0, 1'b0, 3'd0);
    @(negedge clk); @(negedge clk);
    #4;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule